// File: doc/BRIEF.md
# Two-wire register target with time snapshot

This block is the host-side access path of a timekeeping macro. It runs on the system clock, samples the two-wire serial clock and data lines, and acts as a bus target at the fixed 7-bit address 68h. The address byte is therefore D0h for a write and D1h for a read. A write transaction loads a word pointer and then stores bytes at that pointer. A read transaction streams bytes out from the pointer. The pointer advances once for each byte that has been acknowledged.

The block owns the host-visible copies of the eight timekeeping registers (00h–07h). The counting core asks for these copies to be refreshed through a request/acknowledge pair. The block refuses the refresh while a selected host has the pointer inside the time range, so a multi-byte read of the time can never mix values from before and after a tick. Registers 08h–13h belong to the core and are reached through a plain read port and a write strobe. Any completed write into the time range also emits a pulse that restarts the core's sub-second divider.

Top module: `rtc_i2c_target`

## Requirements
- R1: The target acknowledges an address byte of D0h (write) or D1h (read). Any other address byte gets no acknowledge, and the target ignores the bus until the next START.
- R2: In a write transaction, the first byte after the address loads the pointer. Each later byte produces one single-cycle `reg_we_o` pulse carrying the pointer and the byte. The pointer then advances by one.
- R3: A read transaction returns the byte at the pointer and advances the pointer on each master acknowledge. A read issued without a preceding pointer write starts at the pointer value left by the previous access.
- R4: After a master NACK on a read byte, the target releases SDA (`sda_drive_low_o` = 0) so that the master can issue STOP.
- R5: While the target is selected and the pointer is in 00h–07h, `upd_ack_o` stays low and the time copies keep their values. A refresh is taken again after STOP, or once the pointer reaches 08h or above. A taken refresh loads byte k of `time_i` (bits 8k+7..8k) into register k.
- R6: Every completed data write to 00h–07h produces a one-cycle `div_rst_o` pulse, in the same cycle as its `reg_we_o` pulse. A write elsewhere produces no such pulse.
- R7: A data write to address 00h stores and reports 00h, whatever byte was sent.
- R8: Reads of 10h–12h return 00h. Data writes to 10h–12h produce no `reg_we_o` pulse, but the pointer still advances past them.
- R9: The pointer wraps from 13h to 00h. `reg_raddr_o` never exceeds 13h.
- R10: While `pwr_fail_i` is high, the target aborts any access, clears the pointer to 00h, acknowledges nothing and issues no write strobe.
- R11: A pulse on SCL or SDA that lasts only one system-clock sample is filtered out and has no effect on a transfer.
- R12: After reset, SDA is released, no strobe or acknowledge is active, and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as sampled |
| sda_i | input | 1 | Serial data line as sampled |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| pwr_fail_i | input | 1 | Supply out of tolerance; aborts bus access |
| reg_we_o | output | 1 | Register write strobe to the core |
| reg_waddr_o | output | 5 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| div_rst_o | output | 1 | Divider restart pulse after a time-register write |
| reg_raddr_o | output | 5 | Register read address (the word pointer) |
| reg_rdata_i | input | 8 | Read data from the core for 08h–13h |
| upd_req_i | input | 1 | Core has fresh time values pending |
| time_i | input | 64 | Fresh time values, byte k for register k |
| upd_ack_o | output | 1 | Time copies loaded from `time_i` this cycle |

## Verification
The assertions watch the write-strobe side on every cycle:
- a divider pulse always coincides with a strobe into the time range;
- address 00h is always written with zero;
- reserved addresses are never strobed;
- strobes last one cycle;
- the pointer stays in range;
- power failure releases SDA and suppresses strobes from the next cycle on.

Only the bench scenarios can show the protocol-level behaviour: address matching, sequential reads and the resume-from-last-pointer read, the refusal of refreshes while a time read is open, wrap-around, and rejection of a one-sample glitch. Each of these depends on whole bus transactions and on values read back over the wire.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [2:0] {
    LNK_IDLE, LNK_ADDR, LNK_ACK, LNK_RX, LNK_TX, LNK_MACK
  } lnk_state_e;
endpackage

// File: rtl/rtc_i2c_line_filt.sv
module rtc_i2c_line_filt #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  // sh[0..1]: synchronizer, sh[2]: previous synchronized sample
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= {3{RST_VAL}};
      line_o <= RST_VAL;
    end else begin
      sh_q <= {sh_q[1:0], line_i};
      if (sh_q[1] == sh_q[2]) line_o <= sh_q[1];
    end
  end
endmodule

// File: rtl/rtc_i2c_link.sv
module rtc_i2c_link
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_fail_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              sda_low_o,
  output logic              sel_set_o,
  output logic              sel_clr_o,
  output logic              ptr_load_o,
  output logic              wr_o,
  output logic              rd_adv_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  lnk_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, first_q, addr_ack_q, mack_q, scl_p, sda_p;
  logic              scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl_i & ~scl_p;
  assign scl_fall  = ~scl_i & scl_p;
  assign start_det = scl_i & scl_p & sda_p & ~sda_i;
  assign stop_det  = scl_i & scl_p & ~sda_p & sda_i;
  assign rx_byte_o = sh_q;
  assign sda_low_o = (state_q == LNK_ACK) | ((state_q == LNK_TX) & ~sh_q[BYTE_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LNK_IDLE; cnt_q <= '0; sh_q <= '0;
      rw_q <= 1'b0; first_q <= 1'b0; addr_ack_q <= 1'b0; mack_q <= 1'b0;
      scl_p <= 1'b1; sda_p <= 1'b1;
      sel_set_o <= 1'b0; sel_clr_o <= 1'b0; ptr_load_o <= 1'b0;
      wr_o <= 1'b0; rd_adv_o <= 1'b0;
    end else begin
      scl_p <= scl_i; sda_p <= sda_i;
      sel_set_o <= 1'b0; sel_clr_o <= 1'b0; ptr_load_o <= 1'b0;
      wr_o <= 1'b0; rd_adv_o <= 1'b0;
      if (pwr_fail_i) begin
        state_q <= LNK_IDLE;
      end else if (start_det) begin
        state_q <= LNK_ADDR;
        cnt_q   <= '0;
      end else if (stop_det) begin
        state_q   <= LNK_IDLE;
        sel_clr_o <= 1'b1;
      end else begin
        case (state_q)
          LNK_ADDR, LNK_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (state_q == LNK_RX) begin
                state_q    <= LNK_ACK;
                addr_ack_q <= 1'b0;
              end else if (sh_q[7:1] == DEV_ADDR) begin
                state_q    <= LNK_ACK;
                addr_ack_q <= 1'b1;
                rw_q       <= sh_q[0];
                first_q    <= ~sh_q[0];
                sel_set_o  <= 1'b1;
              end else begin
                state_q   <= LNK_IDLE;
                sel_clr_o <= 1'b1;
              end
            end
          end
          LNK_ACK: begin
            if (scl_rise && !addr_ack_q) begin
              if (first_q) ptr_load_o <= 1'b1;
              else         wr_o       <= 1'b1;
              first_q <= 1'b0;
            end else if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                state_q <= LNK_TX;
                sh_q    <= rd_byte_i;
              end else begin
                state_q <= LNK_RX;
              end
            end
          end
          LNK_TX: begin
            if (scl_fall) begin
              if (cnt_q == 4'd7) begin
                state_q <= LNK_MACK;
                mack_q  <= 1'b0;
              end else begin
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                cnt_q <= cnt_q + 4'd1;
              end
            end
          end
          LNK_MACK: begin
            if (scl_rise) begin
              if (!sda_i) begin
                rd_adv_o <= 1'b1;
                mack_q   <= 1'b1;
              end else begin
                state_q <= LNK_IDLE;
              end
            end else if (scl_fall && mack_q) begin
              state_q <= LNK_TX;
              sh_q    <= rd_byte_i;
              cnt_q   <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_i2c_regwin.sv
module rtc_i2c_regwin
  import rtc_i2c_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 20,
  parameter int unsigned TIME_REGS = 8,
  parameter int unsigned RSV_FIRST = 16,
  parameter int unsigned RSV_LAST  = 18,
  localparam int unsigned AW       = $clog2(NUM_REGS),
  localparam int unsigned TW       = $clog2(TIME_REGS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        pwr_fail_i,
  input  logic                        sel_set_i,
  input  logic                        sel_clr_i,
  input  logic                        ptr_load_i,
  input  logic                        wr_i,
  input  logic                        rd_adv_i,
  input  logic [BYTE_W-1:0]           rx_byte_i,
  output logic [BYTE_W-1:0]           rd_byte_o,
  output logic                        we_o,
  output logic [AW-1:0]               waddr_o,
  output logic [BYTE_W-1:0]           wdata_o,
  output logic                        div_rst_o,
  output logic [AW-1:0]               raddr_o,
  input  logic [BYTE_W-1:0]           rdata_i,
  input  logic                        upd_req_i,
  input  logic [TIME_REGS*BYTE_W-1:0] time_i,
  output logic                        upd_ack_o
);
  localparam logic [AW-1:0]     LAST_P = AW'(NUM_REGS - 1);
  localparam logic [AW-1:0]     TLIM   = AW'(TIME_REGS);
  localparam logic [AW-1:0]     RLO    = AW'(RSV_FIRST);
  localparam logic [AW-1:0]     RHI    = AW'(RSV_LAST);
  localparam logic [BYTE_W-1:0] NREG8  = BYTE_W'(NUM_REGS);

  logic [AW-1:0]     ptr_q, ptr_nxt;
  logic              sel_q, in_time, in_rsv, freeze, take;
  logic [BYTE_W-1:0] wval;
  logic [BYTE_W-1:0] snap_q [TIME_REGS];

  assign in_time = ptr_q < TLIM;
  assign in_rsv  = (ptr_q >= RLO) && (ptr_q <= RHI);
  assign ptr_nxt = (ptr_q == LAST_P) ? '0 : ptr_q + AW'(1);
  assign freeze  = sel_q & in_time;
  assign take    = upd_req_i & ~freeze;
  assign wval    = (ptr_q == '0) ? '0 : rx_byte_i;
  assign raddr_o = ptr_q;

  always_comb begin
    if (in_time)     rd_byte_o = snap_q[ptr_q[TW-1:0]];
    else if (in_rsv) rd_byte_o = '0;
    else             rd_byte_o = rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0; sel_q <= 1'b0; we_o <= 1'b0; waddr_o <= '0;
      wdata_o <= '0; div_rst_o <= 1'b0; upd_ack_o <= 1'b0;
      for (int k = 0; k < TIME_REGS; k++) snap_q[k] <= '0;
    end else begin
      we_o <= 1'b0; div_rst_o <= 1'b0; upd_ack_o <= take;
      if (take)
        for (int k = 0; k < TIME_REGS; k++) snap_q[k] <= time_i[k*BYTE_W +: BYTE_W];
      if (pwr_fail_i) begin
        ptr_q <= '0;
        sel_q <= 1'b0;
      end else begin
        if (sel_set_i)      sel_q <= 1'b1;
        else if (sel_clr_i) sel_q <= 1'b0;
        if (ptr_load_i) begin
          ptr_q <= (rx_byte_i < NREG8) ? rx_byte_i[AW-1:0] : '0;
        end else if (wr_i) begin
          ptr_q <= ptr_nxt;
          if (!in_rsv) begin
            we_o    <= 1'b1;
            waddr_o <= ptr_q;
            wdata_o <= wval;
          end
          if (in_time) begin
            div_rst_o                <= 1'b1;
            snap_q[ptr_q[TW-1:0]] <= wval;
          end
        end else if (rd_adv_i) begin
          ptr_q <= ptr_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h68,
  parameter int unsigned NUM_REGS  = 20,
  parameter int unsigned TIME_REGS = 8,
  parameter int unsigned RSV_FIRST = 16,
  parameter int unsigned RSV_LAST  = 18,
  localparam int unsigned AW       = $clog2(NUM_REGS),
  localparam int unsigned TBITS    = TIME_REGS * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low_o,
  input  logic              pwr_fail_i,
  output logic              reg_we_o,
  output logic [AW-1:0]     reg_waddr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              div_rst_o,
  output logic [AW-1:0]     reg_raddr_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  input  logic              upd_req_i,
  input  logic [TBITS-1:0]  time_i,
  output logic              upd_ack_o
);
  logic [1:0]        raw_lines, filt_lines;
  logic              sel_set, sel_clr, ptr_load, wr_evt, rd_adv;
  logic [BYTE_W-1:0] rx_byte, rd_byte;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    rtc_i2c_line_filt #(.RST_VAL(1'b1)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  rtc_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_fail_i (pwr_fail_i),
    .scl_i      (filt_lines[1]),
    .sda_i      (filt_lines[0]),
    .rd_byte_i  (rd_byte),
    .sda_low_o  (sda_drive_low_o),
    .sel_set_o  (sel_set),
    .sel_clr_o  (sel_clr),
    .ptr_load_o (ptr_load),
    .wr_o       (wr_evt),
    .rd_adv_o   (rd_adv),
    .rx_byte_o  (rx_byte)
  );

  rtc_i2c_regwin #(
    .NUM_REGS (NUM_REGS), .TIME_REGS(TIME_REGS),
    .RSV_FIRST(RSV_FIRST), .RSV_LAST(RSV_LAST)
  ) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_fail_i (pwr_fail_i),
    .sel_set_i  (sel_set),
    .sel_clr_i  (sel_clr),
    .ptr_load_i (ptr_load),
    .wr_i       (wr_evt),
    .rd_adv_i   (rd_adv),
    .rx_byte_i  (rx_byte),
    .rd_byte_o  (rd_byte),
    .we_o       (reg_we_o),
    .waddr_o    (reg_waddr_o),
    .wdata_o    (reg_wdata_o),
    .div_rst_o  (div_rst_o),
    .raddr_o    (reg_raddr_o),
    .rdata_i    (reg_rdata_i),
    .upd_req_i  (upd_req_i),
    .time_i     (time_i),
    .upd_ack_o  (upd_ack_o)
  );
endmodule

// File: rtl/rtc_i2c_target_chk.sv
module rtc_i2c_target_chk #(
  parameter int unsigned NUM_REGS  = 20,
  parameter int unsigned TIME_REGS = 8,
  parameter int unsigned RSV_FIRST = 16,
  parameter int unsigned RSV_LAST  = 18,
  localparam int unsigned AW       = $clog2(NUM_REGS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_fail_i,
  input logic          sda_drive_low_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_waddr_o,
  input logic [7:0]    reg_wdata_o,
  input logic          div_rst_o,
  input logic [AW-1:0] reg_raddr_o
);
  localparam logic [AW-1:0] TLIM   = AW'(TIME_REGS);
  localparam logic [AW-1:0] RLO    = AW'(RSV_FIRST);
  localparam logic [AW-1:0] RHI    = AW'(RSV_LAST);
  localparam logic [AW-1:0] LAST_P = AW'(NUM_REGS - 1);

  // R6
  div_with_time_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst_o |-> (reg_we_o && reg_waddr_o < TIME_REGS'(0) + TLIM));
  // R7
  zero_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_waddr_o == '0) |-> reg_wdata_o == 8'h00);
  // R8
  no_rsv_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !(reg_waddr_o >= RLO && reg_waddr_o <= RHI));
  // R9
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_raddr_o <= LAST_P);
  // R2
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R10
  pwr_fail_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> (!sda_drive_low_o && !reg_we_o));
endmodule

bind rtc_i2c_target rtc_i2c_target_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .pwr_fail_i      (pwr_fail_i),
  .sda_drive_low_o (sda_drive_low_o),
  .reg_we_o        (reg_we_o),
  .reg_waddr_o     (reg_waddr_o),
  .reg_wdata_o     (reg_wdata_o),
  .div_rst_o       (div_rst_o),
  .reg_raddr_o     (reg_raddr_o)
);

// File: tb/rtc_i2c_target_bench.sv
module rtc_i2c_target_bench;
  localparam int Q = 10;
  localparam logic [7:0] AW_ADDR = 8'hD0;
  localparam logic [7:0] AR_ADDR = 8'hD1;
  // {addr, data sent, expected readback}
  localparam logic [20:0] VEC [7] = '{
    {5'h08, 8'h3C, 8'h3C}, {5'h09, 8'h81, 8'h81}, {5'h13, 8'hF0, 8'hF0},
    {5'h00, 8'h55, 8'h00}, {5'h10, 8'hAA, 8'h00}, {5'h03, 8'h27, 8'h27},
    {5'h0C, 8'h12, 8'h12}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0, upd_req = 1'b0;
  logic sda_line, sda_low, reg_we, div_rst, upd_ack;
  logic [4:0]  reg_waddr, reg_raddr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [63:0] time_v;
  logic [7:0]  ext_mem [20];
  int checks = 0, errors = 0, wr_cnt = 0, div_cnt = 0, upd_cnt = 0;
  int last_wa = 0, last_wd = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_low;

  for (genvar k = 0; k < 8; k++) begin : g_time
    assign time_v[k*8 +: 8] = 8'h30 + 8'(k);
  end

  always_comb reg_rdata = (reg_raddr < 5'd20) ? ext_mem[reg_raddr] : 8'h00;

  rtc_i2c_target u_rtc_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low_o(sda_low), .pwr_fail_i(pwr_fail),
    .reg_we_o(reg_we), .reg_waddr_o(reg_waddr), .reg_wdata_o(reg_wdata),
    .div_rst_o(div_rst), .reg_raddr_o(reg_raddr), .reg_rdata_i(reg_rdata),
    .upd_req_i(upd_req), .time_i(time_v), .upd_ack_o(upd_ack)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 20; i++) ext_mem[i] = 8'hA0 + 8'(i);
    end else begin
      if (reg_we) begin
        wr_cnt++; last_wa = int'(reg_waddr); last_wd = int'(reg_wdata);
        ext_mem[reg_waddr] = reg_wdata;
      end
      if (div_rst) div_cnt++;
      if (upd_ack) upd_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic byte_in(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~mack);
  endtask

  task automatic wr1(input logic [7:0] p, input logic [7:0] d);
    logic a;
    bstart(); byte_out(AW_ADDR, a); byte_out(p, a); byte_out(d, a); bstop();
  endtask

  task automatic rd1(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bstart(); byte_out(AW_ADDR, a); byte_out(p, a);
    bstart(); byte_out(AR_ADDR, a); byte_in(d, 1'b0); bstop();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wq(190000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    logic a;
    logic [7:0] d;
    logic [4:0] va;
    logic [7:0] vd, ve;
    int w0, d0, u0;
    wq(5); rst_n = 1'b1; wq(5);

    // R12 reset state
    chk("R12 sda", int'(sda_low), 0);
    chk("R12 we", int'(reg_we), 0);
    chk("R12 ptr", int'(reg_raddr), 0);
    chk("R12 ack", int'(upd_ack), 0);

    // R2 R6 R7 R8 table walk: single write then readback
    for (int i = 0; i < 7; i++) begin
      va = VEC[i][20:16]; vd = VEC[i][15:8]; ve = VEC[i][7:0];
      w0 = wr_cnt; d0 = div_cnt;
      wr1({3'b0, va}, vd);
      if (va >= 5'h10 && va <= 5'h12) begin
        chk("R8 no strobe", wr_cnt - w0, 0);
      end else begin
        chk("R2 strobe count", wr_cnt - w0, 1);
        chk("R2 strobe addr", last_wa, int'(va));
        chk("R7 strobe data", last_wd, int'(ve));
      end
      chk("R6 divider pulse", div_cnt - d0, (va < 5'd8) ? 1 : 0);
      rd1({3'b0, va}, d);
      chk("R3 R8 readback", int'(d), int'(ve));
    end

    // R1 wrong address ignored
    w0 = wr_cnt;
    bstart(); byte_out(8'hA0, a);
    chk("R1 nack foreign", int'(a), 0);
    byte_out(8'h08, a);
    chk("R1 idle after foreign", int'(a), 0);
    bstop();
    chk("R1 no strobe", wr_cnt - w0, 0);

    // R9 burst wrapping 13h -> 00h
    w0 = wr_cnt;
    bstart(); byte_out(AW_ADDR, a);
    chk("R1 ack D0", int'(a), 1);
    byte_out(8'h13, a); byte_out(8'h5A, a); byte_out(8'h66, a);
    chk("R9 wrap addr", last_wa, 0);
    chk("R7 wrap data", last_wd, 0);
    byte_out(8'h42, a); byte_out(8'h19, a); bstop();
    chk("R2 burst count", wr_cnt - w0, 4);
    chk("R2 ptr after burst", int'(reg_raddr), 3);

    // R3 read without pointer write starts at 03h
    bstart(); byte_out(AR_ADDR, a);
    chk("R1 ack D1", int'(a), 1);
    byte_in(d, 1'b0);
    chk("R4 release after nack", int'(sda_low), 0);
    bstop();
    chk("R3 resume read", int'(d), 8'h27);

    // R3 sequential read from 00h
    bstart(); byte_out(AW_ADDR, a); byte_out(8'h00, a);
    bstart(); byte_out(AR_ADDR, a);
    byte_in(d, 1'b1); chk("R3 seq byte0", int'(d), 8'h00);
    byte_in(d, 1'b1); chk("R3 seq byte1", int'(d), 8'h42);
    byte_in(d, 1'b0); chk("R3 seq byte2", int'(d), 8'h19);
    chk("R4 sda free", int'(sda_low), 0);
    bstop();

    // R5 freeze while pointer in time range, release on STOP
    bstart(); byte_out(AW_ADDR, a); byte_out(8'h01, a);
    u0 = upd_cnt; upd_req = 1'b1; wq(60);
    chk("R5 frozen", upd_cnt - u0, 0);
    bstop(); wq(20); upd_req = 1'b0; wq(2);
    chk("R5 taken after stop", int'(upd_cnt > u0), 1);
    rd1(8'h05, d);
    chk("R5 copy loaded", int'(d), 8'h35);

    // R5 pointer beyond time range lets the refresh through
    bstart(); byte_out(AW_ADDR, a); byte_out(8'h08, a);
    u0 = upd_cnt; upd_req = 1'b1; wq(30); upd_req = 1'b0; wq(2);
    chk("R5 taken at 08h", int'(upd_cnt > u0), 1);
    bstop();

    // R10 power fail aborts and clears the pointer
    w0 = wr_cnt;
    bstart(); byte_out(AW_ADDR, a); byte_out(8'h09, a);
    pwr_fail = 1'b1; wq(4);
    chk("R10 ptr cleared", int'(reg_raddr), 0);
    byte_out(8'h99, a);
    chk("R10 no ack", int'(a), 0);
    chk("R10 no strobe", wr_cnt - w0, 0);
    pwr_fail = 1'b0; bstop();
    bstart(); byte_out(AR_ADDR, a); byte_in(d, 1'b0); bstop();
    chk("R10 read from 00h", int'(d), 8'h30);

    // R11 one-sample SCL glitch between bytes
    bstart(); byte_out(AW_ADDR, a); byte_out(8'h0A, a);
    @(negedge clk); scl_m = 1'b1; @(negedge clk); scl_m = 1'b0; wq(Q);
    byte_out(8'h6B, a); bstop();
    chk("R11 glitch addr", last_wa, 8'h0A);
    chk("R11 glitch data", last_wd, 8'h6B);

    summary();
  end
endmodule